// File: doc/BRIEF.md
# Video Memory Write Port with Tile Address Remapping

This block turns byte writes from a host processor into byte writes on a 64 KiB video memory organised as 16-bit words. The host loads a word address register. Each write strobe then targets either the even byte or the odd byte of the word that the register points to. The register then steps forward by a programmable stride. One configuration bit selects which of the two byte writes moves the pointer. With this bit, a stream of low/high byte pairs fills consecutive words, and a stream of only-low or only-high bytes fills one byte plane.

Before the word address reaches the memory, it can be passed through a bit rotation. The rotation takes the low field of the address (8, 9 or 10 bits wide) and moves its lowest 5, 6 or 7 bits up by three places, which brings the top three bits of the field down to the bottom. Tile data laid out linearly by the host then lands in the memory in tile-interleaved order. The rotation changes only the memory address. The pointer itself always steps linearly.

Writes are refused while the display is scanning out a visible line, unless forced blanking is on. Lines 0 up to and including the programmed visible height count as blocked. A refused write changes neither the memory nor the pointer. A gate-enable input turns this timing check off.

Top module: `vram_wr_port`

## Requirements
- R1: While reset is held, and in the cycle after it, `mem_we` is 0 and `word_addr` is 0x0000.
- R2: A cycle with `cfg_addr_load` high sets `word_addr` to `cfg_addr_value` at the next edge. A write presented in that same cycle is discarded, so `mem_we` stays 0.
- R3: An accepted write gives `mem_we`=1 one cycle later, with `mem_wdata` equal to the written byte. `mem_addr` is twice the (possibly remapped) word address, truncated to 16 bits, plus `byte_sel`: 0 selects the even byte and 1 selects the odd byte.
- R4: With `cfg_step_on_high`=0, only accepted writes with `byte_sel`=0 advance `word_addr`. With `cfg_step_on_high`=1, only accepted writes with `byte_sel`=1 advance it.
- R5: The stride is set by `cfg_step_sel`: 0 gives 1 word, 1 gives 32 words, and 2 or 3 give 128 words.
- R6: `word_addr` wraps modulo 2^16 when it advances.
- R7: `cfg_remap_sel` picks the rotation. 0 means no remap. 1 uses a field of 8 bits and a shift of 5, 2 uses 9 bits and a shift of 6, and 3 uses 10 bits and a shift of 7. The remapped word is (a & ~m) + ((a & m) >> s) + ((a & (2^s − 1)) << 3), where m is the field mask. The remap never alters how `word_addr` steps.
- R8: With `gate_enable`=1 and `forced_blank`=0, a write on a line where `line_num` ≤ `visible_height` is discarded. `mem_we` stays 0 and `word_addr` is unchanged.
- R9: With `gate_enable`=1, a write is accepted when `forced_blank`=1 or when `line_num` > `visible_height`.
- R10: With `gate_enable`=0, writes are accepted on any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_load | input | 1 | Load the word pointer |
| cfg_addr_value | input | 16 | Value for a pointer load |
| cfg_step_sel | input | 2 | Stride select |
| cfg_step_on_high | input | 1 | 1: the odd-byte write steps the pointer; 0: the even-byte write steps it |
| cfg_remap_sel | input | 2 | Address rotation select |
| wr_en | input | 1 | Byte write strobe |
| byte_sel | input | 1 | 0 = even byte, 1 = odd byte |
| wr_data | input | 8 | Byte to write |
| gate_enable | input | 1 | Enable the display-timing write block |
| forced_blank | input | 1 | Display is forced blank |
| line_num | input | 9 | Current scan line |
| visible_height | input | 9 | Visible line count |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory byte data |
| word_addr | output | 16 | Current word pointer |

## Verification
The hardest case to reach is a pointer that sits exactly at the top of the address space and then takes a large stride. This needs a load near 0xFFFF, the right step trigger and a 128-word stride in one sequence, and the bench builds that sequence through loads followed by single writes. The remap cases use addresses whose field bits are not symmetric, so that a rotation in the wrong direction or the wrong width gives a different byte address. The display-block window is tested at its edges: line 0, a line equal to the height, and the line just past it. The bench then repeats the blocked case with forced blanking on and again with the gate disabled.

// File: rtl/vram_wp_pkg.sv
package vram_wp_pkg;

    typedef enum logic [1:0] {
        REMAP_OFF  = 2'd0,
        REMAP_C32  = 2'd1,
        REMAP_C64  = 2'd2,
        REMAP_C128 = 2'd3
    } remap_sel_e;

    typedef enum logic [1:0] {
        STEP_1    = 2'd0,
        STEP_32   = 2'd1,
        STEP_128  = 2'd2,
        STEP_128B = 2'd3
    } step_sel_e;

    // Distance the low field bits are moved up by the rotation
    localparam int TILE_SHIFT = 3;

    typedef struct packed {
        logic       active;
        logic [3:0] field_bits;
        logic [2:0] shift;
    } remap_cfg_t;

    function automatic remap_cfg_t remap_cfg_f(remap_sel_e sel);
        remap_cfg_t c;
        case (sel)
            REMAP_C32:  c = '{active: 1'b1, field_bits: 4'd8,  shift: 3'd5};
            REMAP_C64:  c = '{active: 1'b1, field_bits: 4'd9,  shift: 3'd6};
            REMAP_C128: c = '{active: 1'b1, field_bits: 4'd10, shift: 3'd7};
            default:    c = '{active: 1'b0, field_bits: 4'd0,  shift: 3'd0};
        endcase
        return c;
    endfunction

    function automatic logic [7:0] step_words_f(step_sel_e sel);
        case (sel)
            STEP_1:  return 8'd1;
            STEP_32: return 8'd32;
            default: return 8'd128;
        endcase
    endfunction

endpackage

// File: rtl/vram_wp_remap.sv
module vram_wp_remap
    import vram_wp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  remap_sel_e        sel,
    output logic [ADDR_W-1:0] addr_out
);
    remap_cfg_t        cfg;
    logic [ADDR_W-1:0] field_mask;
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] field;

    always_comb begin
        cfg        = remap_cfg_f(sel);
        field_mask = (ADDR_W'(1) << cfg.field_bits) - ADDR_W'(1);
        low_mask   = (ADDR_W'(1) << cfg.shift) - ADDR_W'(1);
        field      = addr_in & field_mask;
        if (cfg.active)
            addr_out = (addr_in & ~field_mask)
                     + (field >> cfg.shift)
                     + ((field & low_mask) << TILE_SHIFT);
        else
            addr_out = addr_in;
    end
endmodule

// File: rtl/vram_wp_gate.sv
module vram_wp_gate #(
    parameter int LINE_W = 9
) (
    input  logic              gate_enable,
    input  logic              forced_blank,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] visible_height,
    output logic              blocked
);
    // Line 0 is the pre-display line and the picture occupies lines
    // 1..height, so the blocked window is 0..height inclusive.
    always_comb blocked = gate_enable && !forced_blank && (line_num <= visible_height);
endmodule

// File: rtl/vram_wp_ptr.sv
module vram_wp_ptr
    import vram_wp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_value,
    input  logic              advance,
    input  step_sel_e         step_sel,
    output logic [ADDR_W-1:0] ptr
);
    logic [ADDR_W-1:0] stride;

    always_comb stride = ADDR_W'(step_words_f(step_sel));

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (load)
            ptr <= load_value;
        else if (advance)
            ptr <= ptr + stride;   // wraps modulo 2^ADDR_W
    end
endmodule

// File: rtl/vram_wr_port.sv
module vram_wr_port
    import vram_wp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LINE_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_addr_load,
    input  logic [ADDR_W-1:0] cfg_addr_value,
    input  logic [1:0]        cfg_step_sel,
    input  logic              cfg_step_on_high,
    input  logic [1:0]        cfg_remap_sel,
    input  logic              wr_en,
    input  logic              byte_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              gate_enable,
    input  logic              forced_blank,
    input  logic [LINE_W-1:0] line_num,
    input  logic [LINE_W-1:0] visible_height,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int WORD_KEEP = ADDR_W - 1;

    logic              blocked;
    logic              accepted;
    logic              advance;
    logic [ADDR_W-1:0] mapped_word;
    logic [ADDR_W-1:0] byte_addr;

    vram_wp_gate #(.LINE_W(LINE_W)) gate_i (
        .gate_enable    (gate_enable),
        .forced_blank   (forced_blank),
        .line_num       (line_num),
        .visible_height (visible_height),
        .blocked        (blocked)
    );

    vram_wp_remap #(.ADDR_W(ADDR_W)) remap_i (
        .addr_in  (word_addr),
        .sel      (remap_sel_e'(cfg_remap_sel)),
        .addr_out (mapped_word)
    );

    always_comb begin
        accepted  = wr_en && !cfg_addr_load && !blocked;
        advance   = accepted && (byte_sel == cfg_step_on_high);
        byte_addr = {mapped_word[WORD_KEEP-1:0], byte_sel};
    end

    vram_wp_ptr #(.ADDR_W(ADDR_W)) ptr_i (
        .clk        (clk),
        .rst        (rst),
        .load       (cfg_addr_load),
        .load_value (cfg_addr_value),
        .advance    (advance),
        .step_sel   (step_sel_e'(cfg_step_sel)),
        .ptr        (word_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= accepted;
            if (accepted) begin
                mem_addr  <= byte_addr;
                mem_wdata <= wr_data;
            end
        end
    end
endmodule

// File: rtl/vram_wr_port_chk.sv
module vram_wr_port_chk
    import vram_wp_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_addr_load,
    input logic [ADDR_W-1:0] cfg_addr_value,
    input logic [1:0]        cfg_step_sel,
    input logic              cfg_step_on_high,
    input logic [1:0]        cfg_remap_sel,
    input logic              wr_en,
    input logic              byte_sel,
    input logic              gate_enable,
    input logic              forced_blank,
    input logic [LINE_W-1:0] line_num,
    input logic [LINE_W-1:0] visible_height,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] word_addr
);
    logic in_window;
    logic wr_ok;
    logic [ADDR_W-1:0] stride_c;

    always_comb begin
        in_window = gate_enable && !forced_blank && (line_num <= visible_height);
        wr_ok     = wr_en && !cfg_addr_load && !in_window;
        stride_c  = ADDR_W'(step_words_f(step_sel_e'(cfg_step_sel)));
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!mem_we && word_addr == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_addr_load |=> (word_addr == $past(cfg_addr_value) && !mem_we));

    p_byte_lane_r3: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> (mem_we && mem_addr[0] == $past(byte_sel)));

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && byte_sel != cfg_step_on_high) |=> $stable(word_addr));

    p_stride_wrap_r5_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && byte_sel == cfg_step_on_high) |=>
            (word_addr == $past(word_addr) + $past(stride_c)));

    p_plain_map_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && cfg_remap_sel == 2'd0) |=>
            (mem_addr[ADDR_W-1:1] == $past(word_addr[ADDR_W-2:0])));

    p_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cfg_addr_load && in_window) |=> (!mem_we && $stable(word_addr)));
endmodule

bind vram_wr_port vram_wr_port_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) chk_i (
    .clk              (clk),
    .rst              (rst),
    .cfg_addr_load    (cfg_addr_load),
    .cfg_addr_value   (cfg_addr_value),
    .cfg_step_sel     (cfg_step_sel),
    .cfg_step_on_high (cfg_step_on_high),
    .cfg_remap_sel    (cfg_remap_sel),
    .wr_en            (wr_en),
    .byte_sel         (byte_sel),
    .gate_enable      (gate_enable),
    .forced_blank     (forced_blank),
    .line_num         (line_num),
    .visible_height   (visible_height),
    .mem_we           (mem_we),
    .mem_addr         (mem_addr),
    .word_addr        (word_addr)
);

// File: tb/vram_wr_port_tb.sv
module vram_wr_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_addr_load = 1'b0;
    logic [15:0] cfg_addr_value = '0;
    logic [1:0]  cfg_step_sel = 2'd0;
    logic        cfg_step_on_high = 1'b0;
    logic [1:0]  cfg_remap_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic        byte_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        gate_enable = 1'b1;
    logic        forced_blank = 1'b0;
    logic [8:0]  line_num = 9'd250;
    logic [8:0]  visible_height = 9'd224;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [15:0] word_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    vram_wr_port dut_i (
        .clk(clk), .rst(rst),
        .cfg_addr_load(cfg_addr_load), .cfg_addr_value(cfg_addr_value),
        .cfg_step_sel(cfg_step_sel), .cfg_step_on_high(cfg_step_on_high),
        .cfg_remap_sel(cfg_remap_sel),
        .wr_en(wr_en), .byte_sel(byte_sel), .wr_data(wr_data),
        .gate_enable(gate_enable), .forced_blank(forced_blank),
        .line_num(line_num), .visible_height(visible_height),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .word_addr(word_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic load_ptr(input logic [15:0] a);
        @(negedge clk);
        cfg_addr_load = 1'b1; cfg_addr_value = a;
        @(negedge clk);
        cfg_addr_load = 1'b0;
    endtask

    // one-cycle write strobe; returns with outputs of that write visible
    task automatic write_byte(input bit sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; byte_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(mem_we == 1'b0, "R1 we", 32'(mem_we), 0);
        check(word_addr == 16'h0, "R1 ptr", 32'(word_addr), 0);
    endtask

    task automatic t_load_and_lanes;
        load_ptr(16'h1234);
        check(word_addr == 16'h1234, "R2 load", 32'(word_addr), 32'h1234);
        write_byte(1'b0, 8'hA5);
        check(mem_we == 1'b1, "R3 we", 32'(mem_we), 1);
        check(mem_addr == 16'h2468, "R3 even addr", 32'(mem_addr), 32'h2468);
        check(mem_wdata == 8'hA5, "R3 data", 32'(mem_wdata), 32'hA5);
        write_byte(1'b1, 8'h3C);
        check(mem_addr == 16'h246B, "R3 odd addr after step", 32'(mem_addr), 32'h246B);
        // truncation of the doubled word address
        load_ptr(16'h8001);
        write_byte(1'b1, 8'h11);
        check(mem_addr == 16'h0003, "R3 truncate", 32'(mem_addr), 32'h0003);
        // load and write in one cycle: write dropped
        @(negedge clk);
        cfg_addr_load = 1'b1; cfg_addr_value = 16'h0500; wr_en = 1'b1; byte_sel = 1'b0;
        @(negedge clk);
        cfg_addr_load = 1'b0; wr_en = 1'b0;
        check(mem_we == 1'b0, "R2 write dropped", 32'(mem_we), 0);
        check(word_addr == 16'h0500, "R2 load wins", 32'(word_addr), 32'h0500);
    endtask

    task automatic t_step_trigger;
        cfg_step_sel = 2'd0; cfg_step_on_high = 1'b0;
        load_ptr(16'h0100);
        write_byte(1'b1, 8'h01);
        check(word_addr == 16'h0100, "R4 low-mode hi no step", 32'(word_addr), 32'h0100);
        write_byte(1'b0, 8'h02);
        check(word_addr == 16'h0101, "R4 low-mode lo steps", 32'(word_addr), 32'h0101);
        cfg_step_on_high = 1'b1;
        write_byte(1'b0, 8'h03);
        check(word_addr == 16'h0101, "R4 high-mode lo no step", 32'(word_addr), 32'h0101);
        write_byte(1'b1, 8'h04);
        check(word_addr == 16'h0102, "R4 high-mode hi steps", 32'(word_addr), 32'h0102);
        cfg_step_on_high = 1'b0;
    endtask

    task automatic t_stride_wrap;
        load_ptr(16'h0200);
        cfg_step_sel = 2'd1;
        write_byte(1'b0, 8'h00);
        check(word_addr == 16'h0220, "R5 stride 32", 32'(word_addr), 32'h0220);
        cfg_step_sel = 2'd2;
        write_byte(1'b0, 8'h00);
        check(word_addr == 16'h02A0, "R5 stride 128", 32'(word_addr), 32'h02A0);
        cfg_step_sel = 2'd3;
        write_byte(1'b0, 8'h00);
        check(word_addr == 16'h0320, "R5 stride 128 alt code", 32'(word_addr), 32'h0320);
        load_ptr(16'hFFC0);
        write_byte(1'b0, 8'h00);
        check(word_addr == 16'h0040, "R6 wrap by 128", 32'(word_addr), 32'h0040);
        cfg_step_sel = 2'd0;
        load_ptr(16'hFFFF);
        write_byte(1'b0, 8'h00);
        check(word_addr == 16'h0000, "R6 wrap by 1", 32'(word_addr), 32'h0000);
    endtask

    task automatic t_remap;
        cfg_remap_sel = 2'd1;
        load_ptr(16'h1234);
        write_byte(1'b0, 8'h55);
        check(mem_addr == 16'h2542, "R7 rotate 8/5", 32'(mem_addr), 32'h2542);
        check(word_addr == 16'h1235, "R7 ptr linear", 32'(word_addr), 32'h1235);
        cfg_remap_sel = 2'd2;
        load_ptr(16'h1234);
        write_byte(1'b1, 8'h66);
        check(mem_addr == 16'h2741, "R7 rotate 9/6", 32'(mem_addr), 32'h2741);
        cfg_remap_sel = 2'd3;
        load_ptr(16'h0381);
        write_byte(1'b0, 8'h77);
        check(mem_addr == 16'h001E, "R7 rotate 10/7", 32'(mem_addr), 32'h001E);
        cfg_remap_sel = 2'd0;
    endtask

    task automatic t_gate;
        load_ptr(16'h0040);
        line_num = 9'd100;
        write_byte(1'b0, 8'h99);
        check(mem_we == 1'b0, "R8 mid-display we", 32'(mem_we), 0);
        check(word_addr == 16'h0040, "R8 mid-display ptr", 32'(word_addr), 32'h0040);
        line_num = 9'd0;
        write_byte(1'b0, 8'h99);
        check(mem_we == 1'b0, "R8 line 0", 32'(mem_we), 0);
        line_num = 9'd224;
        write_byte(1'b0, 8'h99);
        check(mem_we == 1'b0 && word_addr == 16'h0040, "R8 line=height",
              32'(word_addr), 32'h0040);
        line_num = 9'd225;
        write_byte(1'b0, 8'h99);
        check(mem_we == 1'b1, "R9 line past height", 32'(mem_we), 1);
        line_num = 9'd100; forced_blank = 1'b1;
        write_byte(1'b0, 8'h99);
        check(mem_we == 1'b1, "R9 forced blank", 32'(mem_we), 1);
        forced_blank = 1'b0; gate_enable = 1'b0;
        write_byte(1'b0, 8'h99);
        check(mem_we == 1'b1 && word_addr == 16'h0043, "R10 gate off",
              32'(word_addr), 32'h0043);
        gate_enable = 1'b1; line_num = 9'd250;
    endtask

    initial begin
        t_reset();
        t_load_and_lanes();
        t_step_trigger();
        t_stride_wrap();
        t_remap();
        t_gate();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule